// File: doc/BRIEF.md
# Local-Bus IDE Data-Port Target Responder

This block is the bus-facing half of an IDE disk port on a 32-bit local processor bus. Every bus clock it samples the active-low address strobe, the memory/IO and write/read status lines, the byte-enable for the upper half-word and the I/O address. When a strobed I/O cycle addresses the primary (0x1F0) or secondary (0x170) data port, it claims the cycle on an active-low local-device output. It then returns completion on the shared, active-low ready line: it drives the line high, pulls it low for exactly one clock, drives it high for one more clock and releases it.

Completion comes no earlier than a parameterised minimum number of clocks after the claim. In enhanced mode a drive flow-control input can stretch the wait further. In legacy mode the same pin has another meaning and never stalls. In the clock where ready is low, the block also pulses a cycle-valid strobe to the downstream register file. The strobe carries the cycle's direction and transfer width, both latched at the claim. The tri-state pad lives at the chip level and is built from the value and enable outputs.

Top module: `ide_lbus_target`

## Requirements
- R1: At a clock edge in idle where `ads_n`=0, `mem_io`=0 (I/O) and `addr` equals 0x1F0 or 0x170, `ldev_n` goes low in the following cycle.
- R2: A strobed cycle with `mem_io`=1 (memory) or any other address is not claimed: `ldev_n` stays 1 and `rdy_oe` stays 0.
- R3: In the cycle the claim appears, `rdy_oe` is 1 with `rdy_n`=1, and `rdy_oe` stays 1 for the whole claimed cycle.
- R4: With no stall, `rdy_n` is 0 in the cycle MIN_WAIT clocks after the claim first appears, and for exactly one cycle.
- R5: In the cycle after `rdy_n` was low, `rdy_n`=1 with `rdy_oe`=1 and `ldev_n`=1. In the cycle after that, `rdy_oe`=0.
- R6: With `mode_enh`=1, each clock edge during the wait at which `iordy_hdc`=0 delays the low ready cycle by one clock.
- R7: With `mode_enh`=0, `iordy_hdc` has no effect on any output timing.
- R8: `cyc_vld` is 1 only in the cycle where `rdy_n` is low. `cyc_wr` then equals the `wr` value sampled at the claim (1 = write). `cyc_wide` equals the inverse of `be2_n` sampled at the claim (1 = 32-bit, 0 = 16-bit).
- R9: An address strobe seen while a claimed cycle is in progress, up to and including the released-hold cycle, starts no new claim.
- R10: While `rst` is 1 at a clock edge, the next cycle shows `rdy_oe`=0, `ldev_n`=1 and `cyc_vld`=0, even in the middle of a claimed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous system reset, active high |
| mode_enh | input | 1 | 1 = enhanced mode (default at pad), 0 = legacy mode |
| ads_n | input | 1 | Address strobe, active low |
| mem_io | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| be2_n | input | 1 | Byte enable 2, active low; low selects a 32-bit transfer |
| addr | input | ADDR_W | I/O address of the current bus cycle |
| iordy_hdc | input | 1 | Drive flow control in enhanced mode (0 = hold off); data/code status in legacy mode |
| ldev_n | output | 1 | Local-device claim, active low |
| rdy_n | output | 1 | Value driven on the shared ready line, active low |
| rdy_oe | output | 1 | Output enable for the ready line; 0 = high impedance |
| cyc_vld | output | 1 | One-clock cycle-complete strobe to the register file |
| cyc_wr | output | 1 | Direction of the completing cycle, 1 = write |
| cyc_wide | output | 1 | Width of the completing cycle, 1 = 32-bit |

## Verification
Call the edge that samples a strobe edge k. The claim and the driven-high ready appear in the cycle after edge k. The low ready cycle and cycle-valid strobe appear MIN_WAIT cycles later, plus one cycle per enhanced-mode stall sample. The driven-high hold follows one cycle after that, and the release one cycle after the hold. The bench applies inputs on the falling edge and compares every output on each falling edge against a table of expected values. It builds that table from the run's start: L = MIN_WAIT + effective stalls, with claim at index 0, low at index L, hold at L+1 and release from L+2. Runs that hold the strobe low through the whole sequence check at index L+3 that no second claim appeared.

// File: rtl/ide_tgt_pkg.sv
package ide_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOW  = 2'd2,
        ST_HOLD = 2'd3
    } rsp_state_e;

    typedef struct packed {
        rsp_state_e state;
        logic       wr;
        logic       wide;
    } rsp_reg_t;

endpackage

// File: rtl/ide_port_decode.sv
module ide_port_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PRI_PORT = 16'h01F0,
    parameter logic [ADDR_W-1:0] SEC_PORT = 16'h0170
) (
    input  logic              strobe_n,
    input  logic              mem_io,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic port_match;

    always_comb begin
        port_match = (addr == PRI_PORT) || (addr == SEC_PORT);
        hit        = !strobe_n && !mem_io && port_match;
    end
endmodule

// File: rtl/ide_wait_timer.sv
module ide_wait_timer #(
    parameter int MIN_WAIT = 2,
    localparam int CW      = (MIN_WAIT < 2) ? 1 : $clog2(MIN_WAIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic stall,
    output logic expire
);
    localparam logic [CW-1:0] LOAD_VAL = CW'(MIN_WAIT);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && !stall && (cnt_q == ONE);
        if (load) begin
            cnt_d = LOAD_VAL;
        end else if (run && !stall && (cnt_q > ONE)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= LOAD_VAL;
        else     cnt_q <= cnt_d;
    end

    // R6: a stalled wait keeps its remaining count
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run && stall && !load) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/ide_lbus_target.sv
module ide_lbus_target #(
    parameter int ADDR_W   = 16,
    parameter int MIN_WAIT = 2,
    parameter logic [ADDR_W-1:0] PRI_PORT = 16'h01F0,
    parameter logic [ADDR_W-1:0] SEC_PORT = 16'h0170
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_enh,
    input  logic              ads_n,
    input  logic              mem_io,
    input  logic              wr,
    input  logic              be2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iordy_hdc,
    output logic              ldev_n,
    output logic              rdy_n,
    output logic              rdy_oe,
    output logic              cyc_vld,
    output logic              cyc_wr,
    output logic              cyc_wide
);
    import ide_tgt_pkg::*;

    logic     port_hit;
    logic     claim;
    logic     in_wait;
    logic     drv_stall;
    logic     wait_done;
    rsp_reg_t r_d, r_q;

    ide_port_decode #(
        .ADDR_W  (ADDR_W),
        .PRI_PORT(PRI_PORT),
        .SEC_PORT(SEC_PORT)
    ) u_decode (
        .strobe_n(ads_n),
        .mem_io  (mem_io),
        .addr    (addr),
        .hit     (port_hit)
    );

    ide_wait_timer #(
        .MIN_WAIT(MIN_WAIT)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (claim),
        .run   (in_wait),
        .stall (drv_stall),
        .expire(wait_done)
    );

    always_comb begin
        r_d       = r_q;
        claim     = (r_q.state == ST_IDLE) && port_hit;
        in_wait   = (r_q.state == ST_WAIT);
        drv_stall = mode_enh && !iordy_hdc;
        unique case (r_q.state)
            ST_IDLE: begin
                if (claim) begin
                    r_d.state = ST_WAIT;
                    r_d.wr    = wr;
                    r_d.wide  = !be2_n;
                end
            end
            ST_WAIT: if (wait_done) r_d.state = ST_LOW;
            ST_LOW:  r_d.state = ST_HOLD;
            ST_HOLD: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_IDLE, wr: 1'b0, wide: 1'b0};
        else     r_q <= r_d;
    end

    always_comb begin
        rdy_oe   = (r_q.state != ST_IDLE);
        rdy_n    = (r_q.state != ST_LOW);
        ldev_n   = !((r_q.state == ST_WAIT) || (r_q.state == ST_LOW));
        cyc_vld  = (r_q.state == ST_LOW);
        cyc_wr   = r_q.wr;
        cyc_wide = r_q.wide;
    end

    // R3: the ready line is driven whenever the cycle is claimed
    assert_claim_drives_R3: assert property (@(posedge clk) disable iff (rst)
        !ldev_n |-> rdy_oe);

    // R4: ready low lasts one clock and is followed by a driven high
    assert_low_one_clk_R4: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && !rdy_n) |=> (rdy_oe && rdy_n));

    // R5: the driven-high hold cycle is followed by release
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && rdy_n && ldev_n) |=> !rdy_oe);

    // R8: cycle-valid only with ready low
    assert_vld_with_low_R8: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |-> (rdy_oe && !rdy_n));

    // R9: no claim restarts while the ready sequence is running
    assert_busy_no_reclaim_R9: assert property (@(posedge clk) disable iff (rst)
        (rdy_oe && ldev_n) |=> ldev_n);

    // R10: reset releases the ready line
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!rdy_oe && ldev_n && !cyc_vld));
endmodule

// File: tb/ide_lbus_target_tb.sv
`timescale 1ns/1ps
module ide_lbus_target_tb;
    localparam int AW = 16;
    localparam int MW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_enh = 1'b1;
    logic ads_n = 1'b1;
    logic mem_io = 1'b0;
    logic wr = 1'b0;
    logic be2_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic iordy_hdc = 1'b1;
    logic ldev_n, rdy_n, rdy_oe, cyc_vld, cyc_wr, cyc_wide;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ide_lbus_target #(.ADDR_W(AW), .MIN_WAIT(MW)) u_dut (
        .clk(clk), .rst(rst), .mode_enh(mode_enh), .ads_n(ads_n),
        .mem_io(mem_io), .wr(wr), .be2_n(be2_n), .addr(addr),
        .iordy_hdc(iordy_hdc), .ldev_n(ldev_n), .rdy_n(rdy_n),
        .rdy_oe(rdy_oe), .cyc_vld(cyc_vld), .cyc_wr(cyc_wr),
        .cyc_wide(cyc_wide)
    );

    // compare {ldev_n, rdy_oe, rdy_n, cyc_vld}; flags only when exp_vld
    task automatic check_out(string tag, logic [3:0] exp, logic chk_flags,
                             logic exp_wr, logic exp_wide);
        logic [3:0] act;
        act = {ldev_n, rdy_oe, rdy_n, cyc_vld};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {ldev_n,rdy_oe,rdy_n,cyc_vld} actual=%b expected=%b", tag, act, exp);
        end
        if (chk_flags) begin
            total++;
            if ({cyc_wr, cyc_wide} !== {exp_wr, exp_wide}) begin
                bad++;
                $display("FAIL R8: {cyc_wr,cyc_wide} actual=%b expected=%b",
                         {cyc_wr, cyc_wide}, {exp_wr, exp_wide});
            end
        end
    endtask

    task automatic run_cycle(logic [AW-1:0] a, logic mio, logic w, logic b2n,
                             logic enh, int stalls, logic hold);
        logic hit;
        int   len;
        hit = (a == 16'h01F0 || a == 16'h0170) && !mio;
        len = MW + (enh ? stalls : 0);
        @(negedge clk);
        mode_enh = enh; addr = a; mem_io = mio; wr = w; be2_n = b2n;
        iordy_hdc = 1'b1; ads_n = 1'b0;
        for (int i = 0; i <= len + 3; i++) begin
            @(negedge clk);
            if (!hit) begin
                check_out("R2 unclaimed cycle", 4'b1010, 1'b0, 1'b0, 1'b0);
            end else if (i < len) begin
                check_out(enh ? "R1 R3 R6 wait" : "R1 R3 R7 wait", 4'b0110, 1'b0, 1'b0, 1'b0);
            end else if (i == len) begin
                check_out(enh ? "R4 R6 low" : "R4 R7 low", 4'b0101, 1'b1, w, !b2n);
            end else if (i == len + 1) begin
                check_out("R5 hold", 4'b1110, 1'b0, 1'b0, 1'b0);
            end else begin
                check_out(hold ? "R5 R9 released" : "R5 released", 4'b1010, 1'b0, 1'b0, 1'b0);
            end
            iordy_hdc = (i + 1 <= stalls) ? 1'b0 : 1'b1;
            ads_n     = (hold && i < len + 2) ? 1'b0 : 1'b1;
        end
        ads_n = 1'b1; iordy_hdc = 1'b1;
    endtask

    initial begin
        logic [AW-1:0] addrs [5];
        addrs[0] = 16'h01F0; addrs[1] = 16'h0170; addrs[2] = 16'h01F1;
        addrs[3] = 16'h00F0; addrs[4] = 16'h03F6;
        repeat (3) @(negedge clk);
        check_out("R10 reset state", 4'b1010, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        for (int ai = 0; ai < 5; ai++)
            for (int m = 0; m < 2; m++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 3; s++)
                        run_cycle(addrs[ai], m[0], s[0] ^ ai[0], ai[1] ^ e[0],
                                  e[0], s, (s == 1) || (ai == 0 && m == 0));
        // R10: reset in the middle of a claimed wait
        @(negedge clk);
        mode_enh = 1'b1; addr = 16'h01F0; mem_io = 1'b0; ads_n = 1'b0; iordy_hdc = 1'b0;
        @(negedge clk);
        ads_n = 1'b1;
        check_out("R1 claim before reset", 4'b0110, 1'b0, 1'b0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_out("R10 mid-cycle reset", 4'b1010, 1'b0, 1'b0, 1'b0);
        rst = 1'b0; iordy_hdc = 1'b1;
        @(negedge clk);
        check_out("R10 idle after reset", 4'b1010, 1'b0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule